// File: doc/BRIEF.md
# Synchronized Processor Clock Gate

This block switches a group of processor clock outputs and a group of memory clock outputs on and off. An active-low stop request that may change at any time controls the switching. The reference clock is passed to every output. Enabled outputs follow it, and a gated output is forced low while its group is off. The request first passes through a two-stage synchronizer clocked by the reference clock. A small controller then decides the enable. It holds the group on for a minimum number of cycles after every turn-on.

The enable reaches the outputs through a level-sensitive stage that is open only while the reference clock is low. Because of this, an output can only stop after a falling edge and can only resume on a rising edge. Every high phase is therefore full width, and a stopped output always rests low. One processor clock and one memory clock bypass the gate and run all the time. A status output gives the enable currently on its way to the gate.

Top module: `clk_stop_ctrl`

## Requirements
- R1: While rst_ni is low, and right after it is released, the gated outputs run and gate_on_o is 1. The release starts a fresh minimum-run window of MIN_RUN cycles.
- R2: stop_ni acts only through two flip-flops clocked on rising edges of clk_i. A low pulse that does not span a rising edge has no effect on any output.
- R3: Every gated output is 0 during every low phase of clk_i. A stopped output stays at 0.
- R4: Every high phase on a gated output is full: the output is 1 for the whole high phase of clk_i or 0 for all of it.
- R5: Turn-off latency. Suppose stop_ni falls in the low phase before rising edge 1 and no window is open. The gated outputs still pulse on edges 1 and 2, and have no pulse from edge 3 on.
- R6: Turn-on latency. Suppose stop_ni rises in the low phase before rising edge 1 while the group is off. There is no pulse on edges 1 and 2, and pulses resume from edge 3.
- R7: Each time the group turns on, it gives at least MIN_RUN consecutive pulses. If stop_ni is held low, the run is exactly MIN_RUN pulses.
- R8: cpu_free_o and mem_free_o equal clk_i at all times, whatever the state of stop_ni.
- R9: In every phase, all bits of cpu_clk_o and mem_clk_o carry the same value.
- R10: A stop request that arrives inside the minimum-run window is held back. It is applied on the first cycle after the window, with no extra delay.
- R11: gate_on_o, read in the low phase before a rising edge, is 1 exactly when the gated outputs pulse on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| stop_ni | input | 1 | Asynchronous active-low stop request |
| cpu_clk_o | output | N_CPU | Gated processor clocks |
| mem_clk_o | output | N_MEM | Gated memory clocks |
| cpu_free_o | output | 1 | Free-running processor clock |
| mem_free_o | output | 1 | Free-running memory clock |
| gate_on_o | output | 1 | Enable presented to the gate this cycle |

## Verification
A stuck or miscounted window counter shows at the ports as a run of pulses whose length is not MIN_RUN. The error is visible within about MIN_RUN+3 cycles of a turn-on with stop held low. A synchronizer that is too deep or too shallow shifts the first missing pulse, or the first returning pulse, by one edge from edge 3. An enable that reaches the gate outside the low phase shows up at once as a short high phase, or as a gated output that is high during a low phase.

// File: rtl/clk_stop_pkg.sv
package clk_stop_pkg;
  localparam int unsigned DEF_N_CPU   = 3;
  localparam int unsigned DEF_N_MEM   = 8;
  localparam int unsigned DEF_MIN_RUN = 100;
  localparam int unsigned DEF_STAGES  = 2;
endpackage

// File: rtl/clk_stop_sync.sv
module clk_stop_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  // resets to "not stopped"
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '1;
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/clk_stop_win.sv
module clk_stop_win #(
  parameter int unsigned MIN_RUN = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_req_i,
  output logic en_o
);
  localparam int unsigned CW = $clog2(MIN_RUN + 1);
  localparam logic [CW-1:0] LIMIT = CW'(MIN_RUN);

  logic          en_q;
  logic [CW-1:0] cnt_q;

  // stay on until the window has seen MIN_RUN enabled cycles
  assign en_o = run_req_i | (en_q & (cnt_q < LIMIT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b1;
      cnt_q <= '0;
    end else begin
      en_q <= en_o;
      if (!en_o)              cnt_q <= '0;
      else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/clk_stop_gate.sv
module clk_stop_gate (
  input  logic clk_i,
  input  logic en_i,
  output logic clk_o
);
  logic en_lat;

  // transparent in low phase only
  always_latch begin
    if (!clk_i) en_lat = en_i;
  end

  assign clk_o = clk_i & en_lat;
endmodule

// File: rtl/clk_stop_ctrl.sv
module clk_stop_ctrl
  import clk_stop_pkg::*;
#(
  parameter int unsigned N_CPU   = DEF_N_CPU,
  parameter int unsigned N_MEM   = DEF_N_MEM,
  parameter int unsigned MIN_RUN = DEF_MIN_RUN,
  parameter int unsigned STAGES  = DEF_STAGES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stop_ni,
  output logic [N_CPU-1:0] cpu_clk_o,
  output logic [N_MEM-1:0] mem_clk_o,
  output logic             cpu_free_o,
  output logic             mem_free_o,
  output logic             gate_on_o
);
  logic run_req;
  logic gate_en;

  clk_stop_sync #(.STAGES(STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (stop_ni),
    .q_o   (run_req)
  );

  clk_stop_win #(.MIN_RUN(MIN_RUN)) u_win (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_req_i(run_req),
    .en_o     (gate_en)
  );

  for (genvar g = 0; g < N_CPU; g++) begin : g_cpu
    clk_stop_gate u_gate (.clk_i(clk_i), .en_i(gate_en), .clk_o(cpu_clk_o[g]));
  end

  for (genvar g = 0; g < N_MEM; g++) begin : g_mem
    clk_stop_gate u_gate (.clk_i(clk_i), .en_i(gate_en), .clk_o(mem_clk_o[g]));
  end

  assign cpu_free_o = clk_i;
  assign mem_free_o = clk_i;
  assign gate_on_o  = gate_en;
endmodule

// File: rtl/clk_stop_chk.sv
module clk_stop_chk #(
  parameter int unsigned N_CPU   = 3,
  parameter int unsigned N_MEM   = 8,
  parameter int unsigned MIN_RUN = 100
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             stop_ni,
  input logic [N_CPU-1:0] cpu_clk_o,
  input logic [N_MEM-1:0] mem_clk_o,
  input logic             cpu_free_o,
  input logic             mem_free_o,
  input logic             gate_on_o
);
  int unsigned run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        run_q <= 0;
    else if (gate_on_o) run_q <= run_q + 1;
    else                run_q <= 0;
  end

  // R3
  low_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_clk_o == '0) && (mem_clk_o == '0));

  // R9
  bus_match_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    ((&cpu_clk_o) || !(|cpu_clk_o)) && ((&mem_clk_o) || !(|mem_clk_o))
    && ((&mem_clk_o) == (&cpu_clk_o)));

  // R11
  status_pred_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    cpu_clk_o[0] == $past(gate_on_o));

  // R7
  min_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q != 0 && !gate_on_o) |-> (run_q >= MIN_RUN));

  // R6
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(stop_ni) |=> gate_on_o);

  // R5
  stay_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(stop_ni) && !stop_ni && !gate_on_o) |=> !gate_on_o);

  // R8
  free_run_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    cpu_free_o && mem_free_o);
endmodule

bind clk_stop_ctrl clk_stop_chk #(
  .N_CPU(N_CPU), .N_MEM(N_MEM), .MIN_RUN(MIN_RUN)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .stop_ni(stop_ni),
  .cpu_clk_o(cpu_clk_o), .mem_clk_o(mem_clk_o),
  .cpu_free_o(cpu_free_o), .mem_free_o(mem_free_o), .gate_on_o(gate_on_o)
);

// File: tb/sim_clk_stop_ctrl.sv
`timescale 1ns/1ps
module sim_clk_stop_ctrl;
  localparam int CLK_P   = 16;
  localparam int N_CPU   = 3;
  localparam int N_MEM   = 8;
  localparam int MIN_RUN = 100;

  logic             clk = 1'b0;
  logic             rst_ni;
  logic             stop_ni;
  logic [N_CPU-1:0] cpu_clk;
  logic [N_MEM-1:0] mem_clk;
  logic             cpu_free, mem_free, gate_on;

  int  n_chk = 0;
  int  n_err = 0;
  bit  exp_next;
  bit  done = 0;

  always #(CLK_P/2) clk = ~clk;

  clk_stop_ctrl #(.N_CPU(N_CPU), .N_MEM(N_MEM), .MIN_RUN(MIN_RUN)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .stop_ni(stop_ni),
    .cpu_clk_o(cpu_clk), .mem_clk_o(mem_clk),
    .cpu_free_o(cpu_free), .mem_free_o(mem_free), .gate_on_o(gate_on)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // one clock: returns pulse seen on this rising edge; exits mid-low
  task automatic tick(output bit pulse);
    logic [N_CPU-1:0] a, b;
    logic [N_MEM-1:0] m;
    @(posedge clk);
    #(CLK_P/8);
    a = cpu_clk; m = mem_clk;
    check(a == '0 || a == '1, "R9", int'(a), 0);
    check(m == {N_MEM{a[0]}}, "R9", int'(m), int'(a[0]));
    check(cpu_free && mem_free, "R8", int'({cpu_free, mem_free}), 3);
    #(CLK_P/4);
    b = cpu_clk;
    check(a == b, "R4", int'(b), int'(a));
    pulse = a[0];
    check(pulse == exp_next, "R11", int'(pulse), int'(exp_next));
    @(negedge clk);
    #(CLK_P/8);
    check(cpu_clk == '0 && mem_clk == '0, "R3", int'(cpu_clk), 0);
    check(!cpu_free && !mem_free, "R8", int'({cpu_free, mem_free}), 0);
    #(CLK_P/8);
    exp_next = gate_on;
  endtask

  initial begin
    #(CLK_P * 200000);
    n_err++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    bit p;
    int run;
    rst_ni = 1'b0;
    stop_ni = 1'b1;
    exp_next = 1'b1;
    repeat (3) @(posedge clk);
    #(CLK_P/8);
    // R1 pulses and status during reset
    check(cpu_clk == '1 && mem_clk == '1, "R1", int'(cpu_clk), 7);
    check(gate_on == 1'b1, "R1", int'(gate_on), 1);
    @(negedge clk);
    #(CLK_P/4);
    rst_ni = 1'b1;
    check(gate_on == 1'b1, "R1", int'(gate_on), 1);

    // R10 R1: stop at once; window from release yields exactly MIN_RUN pulses
    stop_ni = 1'b0;
    run = 0;
    for (int i = 0; i < MIN_RUN + 5; i++) begin
      tick(p);
      if (p) run++;
      check(p == (i < MIN_RUN), "R10", int'(p), int'(i < MIN_RUN));
    end
    check(run == MIN_RUN, "R10", run, MIN_RUN);
    check(gate_on == 1'b0, "R3", int'(gate_on), 0);

    // R6 restart latency
    stop_ni = 1'b1;
    for (int i = 1; i <= 3; i++) begin
      tick(p);
      check(p == (i == 3), "R6", int'(p), int'(i == 3));
    end
    for (int i = 0; i < 300; i++) tick(p);
    check(p == 1'b1, "R6", int'(p), 1);

    // R5 stop latency, window long expired
    stop_ni = 1'b0;
    for (int i = 1; i <= 6; i++) begin
      tick(p);
      check(p == (i <= 2), "R5", int'(p), int'(i <= 2));
    end

    // R2 glitch within a low phase, no rising edge spanned
    stop_ni = 1'b1;
    for (int i = 0; i < MIN_RUN + 20; i++) tick(p);
    stop_ni = 1'b0;
    #(CLK_P/8);
    stop_ni = 1'b1;
    for (int i = 0; i < 6; i++) begin
      tick(p);
      check(p == 1'b1, "R2", int'(p), 1);
    end
    check(gate_on == 1'b1, "R2", int'(gate_on), 1);

    // R7 turn on then request stop right away: run is exactly MIN_RUN
    stop_ni = 1'b0;
    for (int i = 0; i < 8; i++) tick(p);
    check(p == 1'b0, "R5", int'(p), 0);
    stop_ni = 1'b1;
    tick(p);
    tick(p);
    stop_ni = 1'b0;
    run = 0;
    for (int i = 0; i < MIN_RUN + 6; i++) begin
      tick(p);
      if (p) run++;
    end
    check(run == MIN_RUN, "R7", run, MIN_RUN);

    // R7 repeated short requests inside window keep group on
    stop_ni = 1'b1;
    tick(p); tick(p);
    run = 0;
    for (int i = 0; i < MIN_RUN + 10; i++) begin
      stop_ni = (i % 7) < 3;
      tick(p);
      if (p) run++;
    end
    check(run >= MIN_RUN, "R7", run, MIN_RUN);

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    done = 1;
    $finish;
  end
endmodule